// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder

This block receives one 32-bit instruction word per strobe and sorts it into the primary floating-point operate group, the compare group, or no group at all. For a word in a known group, it turns the 9-bit operation code into a short operation identifier. It also gives one operand descriptor for each of the two source fields and the destination field. A descriptor states the operand width (none, single, double or quad) and whether the operand is a raw integer or bit pattern rather than a floating-point value.

The block checks every register number against the width of its operand. Double operands must have even register numbers, and quad operands must have register numbers that are multiples of four. A compare must name condition set zero as its destination. When any of these checks fails, the block reports a register-error trap code. An unrecognised word is marked illegal with no trap code. All results are registered and appear one cycle after the strobe, together with an output valid. Execution units and the trap sequencer use these results.

Top module: `fpop_decoder`

## Requirements
- R1: `out_class` is 1 when `insn & 0xC1F80000 == 0x81A00000`, 2 when the masked value is `0x81A80000`, and 0 otherwise.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and low in every other cycle. Result fields are updated only on a strobe.
- R3: `out_rs1`, `out_rs2` and `out_rd` carry `insn[18:14]`, `insn[4:0]` and `insn[29:25]` of the strobed word. The operation code is `insn[13:5]`.
- R4: The arithmetic operations in class 1 decode to the following operation identifiers: add=1, sub=2, mul=3, div=4 and sqrt=5. Their codes are 0x041–0x043, 0x045–0x047, 0x049–0x04B, 0x04D–0x04F and 0x029–0x02B for single, double and quad. All operand descriptors have the operation's width. Sqrt has no rs1 operand. The widening multiplies are 0x069 (single to double) and 0x06E (double to quad), with identifier 12.
- R5: The conversions have identifier 9, and each carries its own pair of widths. Descriptor encoding: bit 2 marks a raw integer operand, and bits 1:0 give the width (0 none, 1 single, 2 double, 3 quad). The integer-to-float codes 0x0C4, 0x0C8 and 0x0CC take a raw single source, which is not alignment-checked. The float-to-integer codes 0x0D1, 0x0D2 and 0x0D3 write a raw single result. Float-to-float conversions use 0x0C6, 0x0C7, 0x0C9, 0x0CB, 0x0CD and 0x0CE.
- R6: Move 0x001 (id 6), negate 0x005 (id 7) and absolute 0x009 (id 8) have a raw single rs2 and a raw single rd, and no rs1.
- R7: A double operand with an odd register number makes `out_illegal`=1 and `out_trap`=6. The trap code is cleared for every new decode.
- R8: A quad operand whose register number has bit 1 or bit 0 set makes `out_illegal`=1 and `out_trap`=6. A field whose descriptor is none is not checked.
- R9: The class 2 compares are 0x051/0x052/0x053, with identifier 10, and the exception-signalling compares are 0x055/0x056/0x057, with identifier 11. They have no rd descriptor. A nonzero rd field gives `out_illegal`=1 and `out_trap`=6.
- R10: An unmatched opcode within a class, or a word that matches no class, gives operation 0, all descriptors 0, `out_illegal`=1 and `out_trap`=0.
- R11: In reset, `out_valid`, `out_illegal` and `out_trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| out_class | output | 2 | 0 none, 1 operate, 2 compare group |
| out_op | output | 4 | Operation identifier |
| out_rs1_desc | output | 3 | rs1 descriptor {raw, width} |
| out_rs2_desc | output | 3 | rs2 descriptor {raw, width} |
| out_rd_desc | output | 3 | rd descriptor {raw, width} |
| out_rs1 | output | 5 | rs1 register number |
| out_rs2 | output | 5 | rs2 register number |
| out_rd | output | 5 | rd register number |
| out_illegal | output | 1 | Unrecognised or register error |
| out_trap | output | 3 | 6 on register error, else 0 |

## Verification
On every cycle, the assertions check the strobe-to-valid timing and the copying of the register fields. They also check that a trap code always comes with the illegal flag, that an accepted double or quad operand has an aligned register number, and that an accepted compare has a zero destination. Only the bench scenarios can show the opcode table itself. That covers which code maps to which identifier and width pair, that raw integer sources escape the alignment check, and that compare codes placed in the wrong class are refused.

// File: rtl/fpop_decoder.sv
module fpop_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] insn,
  output logic        out_valid,
  output logic [1:0]  out_class,
  output logic [3:0]  out_op,
  output logic [2:0]  out_rs1_desc,
  output logic [2:0]  out_rs2_desc,
  output logic [2:0]  out_rd_desc,
  output logic [4:0]  out_rs1,
  output logic [4:0]  out_rs2,
  output logic [4:0]  out_rd,
  output logic        out_illegal,
  output logic [2:0]  out_trap
);
  localparam logic [31:0] CLASS_MASK = 32'hC1F8_0000;
  localparam logic [31:0] CLASS_OP1  = 32'h81A0_0000;
  localparam logic [31:0] CLASS_OP2  = 32'h81A8_0000;
  localparam logic [2:0]  TRAP_REG   = 3'd6;

  localparam logic [2:0] DN = 3'd0, DS = 3'd1, DD = 3'd2, DQ = 3'd3, DI = 3'd5;

  localparam logic [3:0] OP_NONE = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_MUL = 4'd3,
                         OP_DIV = 4'd4, OP_SQRT = 4'd5, OP_MOV = 4'd6, OP_NEG = 4'd7,
                         OP_ABS = 4'd8, OP_CVT = 4'd9, OP_CMP = 4'd10, OP_CMPE = 4'd11,
                         OP_WMUL = 4'd12;

  wire [8:0] opc = insn[13:5];
  wire [4:0] f1  = insn[18:14];
  wire [4:0] f2  = insn[4:0];
  wire [4:0] fd  = insn[29:25];
  wire is_op1 = (insn & CLASS_MASK) == CLASS_OP1;
  wire is_op2 = (insn & CLASS_MASK) == CLASS_OP2;

  logic [3:0] op;
  logic [2:0] d_rd, d_rs2, d_rs1;

  always_comb begin
    {op, d_rd, d_rs2, d_rs1} = {OP_NONE, DN, DN, DN};
    if (is_op1) begin
      case (opc)
        9'h041: {op, d_rd, d_rs2, d_rs1} = {OP_ADD,  DS, DS, DS};
        9'h042: {op, d_rd, d_rs2, d_rs1} = {OP_ADD,  DD, DD, DD};
        9'h043: {op, d_rd, d_rs2, d_rs1} = {OP_ADD,  DQ, DQ, DQ};
        9'h045: {op, d_rd, d_rs2, d_rs1} = {OP_SUB,  DS, DS, DS};
        9'h046: {op, d_rd, d_rs2, d_rs1} = {OP_SUB,  DD, DD, DD};
        9'h047: {op, d_rd, d_rs2, d_rs1} = {OP_SUB,  DQ, DQ, DQ};
        9'h049: {op, d_rd, d_rs2, d_rs1} = {OP_MUL,  DS, DS, DS};
        9'h04A: {op, d_rd, d_rs2, d_rs1} = {OP_MUL,  DD, DD, DD};
        9'h04B: {op, d_rd, d_rs2, d_rs1} = {OP_MUL,  DQ, DQ, DQ};
        9'h04D: {op, d_rd, d_rs2, d_rs1} = {OP_DIV,  DS, DS, DS};
        9'h04E: {op, d_rd, d_rs2, d_rs1} = {OP_DIV,  DD, DD, DD};
        9'h04F: {op, d_rd, d_rs2, d_rs1} = {OP_DIV,  DQ, DQ, DQ};
        9'h029: {op, d_rd, d_rs2, d_rs1} = {OP_SQRT, DS, DS, DN};
        9'h02A: {op, d_rd, d_rs2, d_rs1} = {OP_SQRT, DD, DD, DN};
        9'h02B: {op, d_rd, d_rs2, d_rs1} = {OP_SQRT, DQ, DQ, DN};
        9'h069: {op, d_rd, d_rs2, d_rs1} = {OP_WMUL, DD, DS, DS};
        9'h06E: {op, d_rd, d_rs2, d_rs1} = {OP_WMUL, DQ, DD, DD};
        9'h001: {op, d_rd, d_rs2, d_rs1} = {OP_MOV,  DI, DI, DN};
        9'h005: {op, d_rd, d_rs2, d_rs1} = {OP_NEG,  DI, DI, DN};
        9'h009: {op, d_rd, d_rs2, d_rs1} = {OP_ABS,  DI, DI, DN};
        9'h0C4: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DS, DI, DN};
        9'h0C8: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DD, DI, DN};
        9'h0CC: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DQ, DI, DN};
        9'h0D1: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DI, DS, DN};
        9'h0D2: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DI, DD, DN};
        9'h0D3: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DI, DQ, DN};
        9'h0C6: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DS, DD, DN};
        9'h0C7: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DS, DQ, DN};
        9'h0C9: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DD, DS, DN};
        9'h0CB: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DD, DQ, DN};
        9'h0CD: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DQ, DS, DN};
        9'h0CE: {op, d_rd, d_rs2, d_rs1} = {OP_CVT,  DQ, DD, DN};
        default: ;
      endcase
    end else if (is_op2) begin
      case (opc)
        9'h051: {op, d_rd, d_rs2, d_rs1} = {OP_CMP,  DN, DS, DS};
        9'h052: {op, d_rd, d_rs2, d_rs1} = {OP_CMP,  DN, DD, DD};
        9'h053: {op, d_rd, d_rs2, d_rs1} = {OP_CMP,  DN, DQ, DQ};
        9'h055: {op, d_rd, d_rs2, d_rs1} = {OP_CMPE, DN, DS, DS};
        9'h056: {op, d_rd, d_rs2, d_rs1} = {OP_CMPE, DN, DD, DD};
        9'h057: {op, d_rd, d_rs2, d_rs1} = {OP_CMPE, DN, DQ, DQ};
        default: ;
      endcase
    end
  end

  function automatic logic misaligned(input logic [2:0] d, input logic [4:0] r);
    if (d[2]) return 1'b0;
    case (d[1:0])
      2'd2:    return r[0];
      2'd3:    return |r[1:0];
      default: return 1'b0;
    endcase
  endfunction

  wire is_cmp  = (op == OP_CMP) || (op == OP_CMPE);
  wire reg_err = (op != OP_NONE) &&
                 (misaligned(d_rs1, f1) || misaligned(d_rs2, f2) ||
                  misaligned(d_rd, fd) || (is_cmp && fd != 5'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_class    <= 2'd0;
      out_op       <= OP_NONE;
      out_rs1_desc <= DN;
      out_rs2_desc <= DN;
      out_rd_desc  <= DN;
      out_rs1      <= 5'd0;
      out_rs2      <= 5'd0;
      out_rd       <= 5'd0;
      out_illegal  <= 1'b0;
      out_trap     <= 3'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_class    <= is_op1 ? 2'd1 : (is_op2 ? 2'd2 : 2'd0);
        out_op       <= op;
        out_rs1_desc <= d_rs1;
        out_rs2_desc <= d_rs2;
        out_rd_desc  <= d_rd;
        out_rs1      <= f1;
        out_rs2      <= f2;
        out_rd       <= fd;
        out_illegal  <= (op == OP_NONE) || reg_err;
        out_trap     <= reg_err ? TRAP_REG : 3'd0;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_FIELDS_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_rd == $past(insn[29:25]) && out_rs1 == $past(insn[18:14]) && out_rs2 == $past(insn[4:0]))); // R3
  AST_TRAP_IS_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_trap != 3'd0) |-> (out_illegal && out_trap == TRAP_REG)); // R7
  AST_UNKNOWN_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op == OP_NONE) |-> (out_illegal && out_trap == 3'd0 && out_rd_desc == DN)); // R10
  AST_DOUBLE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && out_rs1_desc == DD) |-> !out_rs1[0]); // R7
  AST_QUAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && out_rs2_desc == DQ) |-> (out_rs2[1:0] == 2'd0)); // R8
  AST_CMP_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && (out_op == OP_CMP || out_op == OP_CMPE)) |-> (out_rd == 5'd0)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst_n) |=> (!out_valid && out_trap == 3'd0)); // R11
endmodule

// File: tb/fpop_decoder_tb.sv
module fpop_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] insn = 0;
  logic out_valid, out_illegal;
  logic [1:0] out_class;
  logic [3:0] out_op;
  logic [2:0] out_rs1_desc, out_rs2_desc, out_rd_desc, out_trap;
  logic [4:0] out_rs1, out_rs2, out_rd;

  fpop_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .out_valid(out_valid), .out_class(out_class), .out_op(out_op),
    .out_rs1_desc(out_rs1_desc), .out_rs2_desc(out_rs2_desc), .out_rd_desc(out_rd_desc),
    .out_rs1(out_rs1), .out_rs2(out_rs2), .out_rd(out_rd),
    .out_illegal(out_illegal), .out_trap(out_trap));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] w;
    logic [1:0]  cls;
    logic [3:0]  op;
    logic [2:0]  drd, d2, d1;
    logic        ill;
    logic [2:0]  trap;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [2:0] N = 0, S = 1, D = 2, Q = 3, I = 5;

  function automatic logic [31:0] mk(input int grp, input logic [8:0] opc,
                                     input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2);
    return {2'b10, rd, (grp == 2) ? 6'b110101 : 6'b110100, r1, opc, r2};
  endfunction

  task automatic send(input logic [31:0] w, input logic [1:0] cls, input logic [3:0] op,
                      input logic [2:0] drd, input logic [2:0] d2, input logic [2:0] d1,
                      input logic ill, input logic [2:0] trap, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1; insn = w;
    e.w = w; e.cls = cls; e.op = op; e.drd = drd; e.d2 = d2; e.d1 = d1;
    e.ill = ill; e.trap = trap; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle_check(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; insn = 32'hFFFF_FFFF;
    end
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle: out_valid actual %b expected 0", out_valid);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (out_class !== e.cls || out_op !== e.op || out_rd_desc !== e.drd ||
            out_rs2_desc !== e.d2 || out_rs1_desc !== e.d1 || out_illegal !== e.ill ||
            out_trap !== e.trap || out_rd !== e.w[29:25] || out_rs1 !== e.w[18:14] ||
            out_rs2 !== e.w[4:0]) begin
          fails++;
          $display("FAIL %s insn=%h: actual cls=%0d op=%0d d=%0d/%0d/%0d ill=%b trap=%0d regs=%0d/%0d/%0d expected cls=%0d op=%0d d=%0d/%0d/%0d ill=%b trap=%0d regs=%0d/%0d/%0d",
                   e.tag, e.w, out_class, out_op, out_rd_desc, out_rs2_desc, out_rs1_desc,
                   out_illegal, out_trap, out_rd, out_rs1, out_rs2,
                   e.cls, e.op, e.drd, e.d2, e.d1, e.ill, e.trap, e.w[29:25], e.w[18:14], e.w[4:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_illegal !== 0 || out_trap !== 0) begin
      fails++;
      $display("FAIL R11 reset: actual v=%b ill=%b trap=%0d expected 0 0 0", out_valid, out_illegal, out_trap);
    end
    rst_n = 1;

    send(mk(1, 9'h041, 2, 4, 6), 1, 1, S, S, S, 0, 0, "R1 R3 R4 add single");
    send(mk(1, 9'h042, 2, 4, 6), 1, 1, D, D, D, 0, 0, "R4 add double");
    send(mk(1, 9'h047, 4, 8, 12), 1, 2, Q, Q, Q, 0, 0, "R4 sub quad");
    send(mk(1, 9'h04E, 0, 30, 2), 1, 4, D, D, D, 0, 0, "R4 div double");
    send(mk(1, 9'h02B, 8, 7, 4), 1, 5, Q, Q, N, 0, 0, "R4 R8 sqrt quad rs1 unchecked");
    send(mk(1, 9'h069, 2, 1, 3), 1, 12, D, S, S, 0, 0, "R4 widening mul");
    send(mk(1, 9'h06E, 4, 2, 6), 1, 12, Q, D, D, 0, 0, "R4 widening mul quad");
    idle_check(2);

    send(mk(1, 9'h0C8, 4, 0, 3), 1, 9, D, I, N, 0, 0, "R5 int to double odd src ok");
    send(mk(1, 9'h0D2, 3, 0, 2), 1, 9, I, D, N, 0, 0, "R5 double to int odd rd ok");
    send(mk(1, 9'h0CE, 8, 0, 6), 1, 9, Q, D, N, 0, 0, "R5 double to quad");
    send(mk(1, 9'h0C7, 9, 0, 4), 1, 9, S, Q, N, 0, 0, "R5 quad to single");
    send(mk(1, 9'h005, 1, 0, 3), 1, 7, I, I, N, 0, 0, "R6 negate");
    send(mk(1, 9'h009, 7, 0, 9), 1, 8, I, I, N, 0, 0, "R6 absolute");
    send(mk(1, 9'h001, 5, 0, 11), 1, 6, I, I, N, 0, 0, "R6 move");
    idle_check(1);

    send(mk(1, 9'h042, 2, 5, 6), 1, 1, D, D, D, 1, 6, "R7 odd double rs1");
    send(mk(1, 9'h04A, 3, 4, 6), 1, 3, D, D, D, 1, 6, "R7 odd double rd");
    send(mk(1, 9'h041, 3, 5, 7), 1, 1, S, S, S, 0, 0, "R7 trap cleared next decode");
    send(mk(1, 9'h04B, 4, 8, 2), 1, 3, Q, Q, Q, 1, 6, "R8 quad rs2 bit1");
    send(mk(1, 9'h0CD, 5, 0, 1), 1, 9, Q, S, N, 1, 6, "R8 quad rd bit0");
    send(mk(1, 9'h0D3, 1, 0, 4), 1, 9, I, Q, N, 0, 0, "R8 quad aligned ok");

    send(mk(2, 9'h052, 0, 2, 4), 2, 10, N, D, D, 0, 0, "R1 R9 compare double");
    send(mk(2, 9'h057, 0, 4, 8), 2, 11, N, Q, Q, 0, 0, "R9 signalling compare quad");
    send(mk(2, 9'h055, 1, 3, 5), 2, 11, N, S, S, 1, 6, "R9 compare nonzero rd");
    send(mk(2, 9'h053, 0, 4, 6), 2, 10, N, Q, Q, 1, 6, "R9 R8 compare quad misaligned");

    send(mk(1, 9'h0FF, 2, 4, 6), 1, 0, N, N, N, 1, 0, "R10 unknown op class1");
    send(mk(1, 9'h051, 0, 2, 4), 1, 0, N, N, N, 1, 0, "R10 compare code in class1");
    send(mk(2, 9'h041, 2, 4, 6), 2, 0, N, N, N, 1, 0, "R10 add code in class2");
    send(32'h0000_0000, 0, 0, N, N, N, 1, 0, "R1 R10 non-fp word");
    send(32'hC1A0_0820, 0, 0, N, N, N, 1, 0, "R1 R10 wrong top bits");
    idle_check(3);

    repeat (3) @(negedge clk);
    done = 1;
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2 missing results: actual %0d pending expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule